// File: doc/BRIEF.md
# Prescaled Periodic Down-Counting Timer

This block is a free-running periodic timer driven by the system clock. A reloadable prescaler divides the clock and emits one tick each time it runs out. Each tick steps a 32-bit down counter, which is reloaded from a 32-bit period value after it passes zero. That wrap sets an interrupt flag, and the flag drives the interrupt line when the interrupt is enabled.

Software reaches the timer through a 16-bit word register port with single-cycle writes and combinational reads. The 32-bit counter and period are each split into a low word and a high word. A control word holds these fields:
- a run/stop switch
- a one-shot reload command
- the interrupt enable
- a flag that is cleared by writing 1
- a two-bit field that sets how the timer behaves while the halt input is high

Top module: `tmr_top`

## Requirements
- R1: After reset the counter and period words read 0xFFFF, both prescaler words read 0x0000, the control word reads 0x0010 (stopped) and `irq` is low.
- R2: While running, the prescaler counts down from the divide-down value and ticks when it is at zero. A tick therefore comes every divide-down+1 clocks, and each tick lowers a nonzero counter by one.
- R3: Writing control bit 5 as 1 loads the counter from the period and the prescaler from the divide-down value in that same cycle. Bit 5 always reads 0.
- R4: While control bit 4 is 1, the counter and the prescaler hold their values.
- R5: A tick that finds the counter at zero reloads it from the period and sets the flag (control bit 15). The flag therefore rises every (divide-down+1)*(period+1) clocks after a start from a fresh reload.
- R6: `irq` is high exactly when the flag and the enable (control bit 14) are both set.
- R7: Writing 1 to control bit 15 clears the flag. Writing 0 to it leaves the flag unchanged.
- R8: With control bits 11:10 = 00, a high `haltIn` freezes the timer at once, and counting resumes when `haltIn` falls.
- R9: With control bits 11:10 = 01 and `haltIn` high, the timer keeps counting until the counter reaches zero and then holds at zero without wrapping.
- R10: With control bit 11 set, `haltIn` has no effect.
- R11: The word offsets are:
  - counter low 0, counter high 1
  - period low 2, period high 3
  - control 4
  - prescaler low 6, prescaler high 7

  Offset 5 reads 0. The counter words are writable. Each prescaler word holds its half of the live prescaler count in bits 15:8 (read-only) and its half of the divide-down value in bits 7:0 (read/write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| haltIn | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The stimulus table sweeps several period and divide-down pairs, including both set to zero. A timer that counted period ticks instead of period+1, or that ignored the prescaler, would raise `irq` one tick early or at the wrong rate.

The directed tests cover the following cases:
- Each halt mode. A design that mixed up the zero-stop mode would either freeze at once or wrap and set the flag.
- The write-1-to-clear flag. A design that cleared it on any control write would lose the flag when a 0 is written.
- Reload of the prescaler as well as the counter, checked through the live prescaler count byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_BUS_W = 16;
  localparam int TMR_ADR_W = 3;

  localparam logic [TMR_ADR_W-1:0] ADR_CNT_LO = 3'd0;
  localparam logic [TMR_ADR_W-1:0] ADR_CNT_HI = 3'd1;
  localparam logic [TMR_ADR_W-1:0] ADR_PRD_LO = 3'd2;
  localparam logic [TMR_ADR_W-1:0] ADR_PRD_HI = 3'd3;
  localparam logic [TMR_ADR_W-1:0] ADR_CTRL   = 3'd4;
  localparam logic [TMR_ADR_W-1:0] ADR_PSC_LO = 3'd6;
  localparam logic [TMR_ADR_W-1:0] ADR_PSC_HI = 3'd7;

  localparam int BIT_FLAG   = 15;
  localparam int BIT_IE     = 14;
  localparam int BIT_EMU_HI = 11;
  localparam int BIT_EMU_LO = 10;
  localparam int BIT_RELOAD = 5;
  localparam int BIT_STOP   = 4;

  typedef struct packed {
    logic reload;
    logic runEn;
    logic wrCntLo;
    logic wrCntHi;
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int BUS_W = TMR_BUS_W,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strb,
  input  logic [BUS_W-1:0] wrData,
  input  logic [CNT_W-1:0] period,
  input  logic [BUS_W-1:0] divDown,
  output logic [CNT_W-1:0] cnt,
  output logic [BUS_W-1:0] pscCnt,
  output logic             tick,
  output logic             wrapEvt,
  output logic             cntZero
);
  logic cntWrite;

  assign cntWrite = strb.wrCntLo | strb.wrCntHi;
  assign cntZero  = (cnt == '0);
  assign tick     = strb.runEn && (pscCnt == '0);
  assign wrapEvt  = tick && cntZero && !strb.reload && !cntWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (strb.reload) begin
      pscCnt <= divDown;
    end else if (strb.runEn) begin
      pscCnt <= (pscCnt == '0) ? divDown : pscCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (strb.reload) begin
      cnt <= period;
    end else if (strb.wrCntLo) begin
      cnt[BUS_W-1:0] <= wrData;
    end else if (strb.wrCntHi) begin
      cnt[CNT_W-1:BUS_W] <= wrData;
    end else if (tick) begin
      cnt <= cntZero ? period : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BUS_W = TMR_BUS_W,
  localparam int CNT_W = 2 * BUS_W,
  localparam int HALF  = BUS_W / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [TMR_ADR_W-1:0] addr,
  input  logic [BUS_W-1:0]     wrData,
  input  logic                 haltIn,
  input  logic                 cntZero,
  input  logic                 wrapEvt,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [BUS_W-1:0]     pscCnt,
  output tmrStrobes_t          strb,
  output logic [CNT_W-1:0]     period,
  output logic [BUS_W-1:0]     divDown,
  output logic [BUS_W-1:0]     rdData,
  output logic                 flagQ,
  output logic [1:0]           emuQ,
  output logic                 irq
);
  logic ieQ;
  logic stopQ;
  logic wrCtl;
  logic haltStop;

  assign wrCtl = wrEn && (addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period  <= '1;
      divDown <= '0;
      ieQ     <= 1'b0;
      emuQ    <= 2'b00;
      stopQ   <= 1'b1;
      flagQ   <= 1'b0;
    end else begin
      if (wrEn && addr == ADR_PRD_LO) period[BUS_W-1:0]     <= wrData;
      if (wrEn && addr == ADR_PRD_HI) period[CNT_W-1:BUS_W] <= wrData;
      if (wrEn && addr == ADR_PSC_LO) divDown[HALF-1:0]     <= wrData[HALF-1:0];
      if (wrEn && addr == ADR_PSC_HI) divDown[BUS_W-1:HALF] <= wrData[HALF-1:0];
      if (wrCtl) begin
        ieQ   <= wrData[BIT_IE];
        emuQ  <= wrData[BIT_EMU_HI:BIT_EMU_LO];
        stopQ <= wrData[BIT_STOP];
      end
      if (wrapEvt) flagQ <= 1'b1;
      else if (wrCtl && wrData[BIT_FLAG]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    haltStop = 1'b0;
    if (haltIn) begin
      case (emuQ)
        2'b00:   haltStop = 1'b1;
        2'b01:   haltStop = cntZero;
        default: haltStop = 1'b0;
      endcase
    end
  end

  always_comb begin
    strb.reload  = wrCtl && wrData[BIT_RELOAD];
    strb.runEn   = !stopQ && !haltStop;
    strb.wrCntLo = wrEn && (addr == ADR_CNT_LO);
    strb.wrCntHi = wrEn && (addr == ADR_CNT_HI);
  end

  always_comb begin
    case (addr)
      ADR_CNT_LO: rdData = cnt[BUS_W-1:0];
      ADR_CNT_HI: rdData = cnt[CNT_W-1:BUS_W];
      ADR_PRD_LO: rdData = period[BUS_W-1:0];
      ADR_PRD_HI: rdData = period[CNT_W-1:BUS_W];
      ADR_CTRL:   rdData = {flagQ, ieQ, 2'b00, emuQ, 4'b0000, 1'b0, stopQ, 4'b0000};
      ADR_PSC_LO: rdData = {pscCnt[HALF-1:0], divDown[HALF-1:0]};
      ADR_PSC_HI: rdData = {pscCnt[BUS_W-1:HALF], divDown[BUS_W-1:HALF]};
      default:    rdData = '0;
    endcase
  end

  assign irq = flagQ & ieQ;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int BUS_W = TMR_BUS_W,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [TMR_ADR_W-1:0] addr,
  input  logic [BUS_W-1:0]     wrData,
  output logic [BUS_W-1:0]     rdData,
  input  logic                 haltIn,
  output logic                 irq
);
  tmrStrobes_t      strb;
  logic [CNT_W-1:0] period;
  logic [BUS_W-1:0] divDown;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] pscCnt;
  logic             tick;
  logic             wrapEvt;
  logic             cntZero;
  logic             flagQ;
  logic [1:0]       emuQ;

  tmr_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .haltIn(haltIn), .cntZero(cntZero), .wrapEvt(wrapEvt), .cnt(cnt),
    .pscCnt(pscCnt), .strb(strb), .period(period), .divDown(divDown),
    .rdData(rdData), .flagQ(flagQ), .emuQ(emuQ), .irq(irq)
  );

  tmr_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .period(period),
    .divDown(divDown), .cnt(cnt), .pscCnt(pscCnt), .tick(tick),
    .wrapEvt(wrapEvt), .cntZero(cntZero)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int BUS_W = TMR_BUS_W,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rstN,
  input tmrStrobes_t      strb,
  input logic [CNT_W-1:0] cnt,
  input logic [BUS_W-1:0] pscCnt,
  input logic [CNT_W-1:0] period,
  input logic             tick,
  input logic             flagQ,
  input logic             haltIn,
  input logic [1:0]       emu
);
  // R3: a reload command lands the period in the counter
  p_reload_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.reload) |-> cnt == $past(period));

  // R4: nothing moves while the run enable is low
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.runEn) && !$past(strb.reload) && !$past(strb.wrCntLo) && !$past(strb.wrCntHi))
    |-> ($stable(cnt) && $stable(pscCnt)));

  // R2: a tick on a nonzero counter lowers it by one
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tick) && $past(cnt) != '0 && !$past(strb.reload) && !$past(strb.wrCntLo) && !$past(strb.wrCntHi))
    |-> cnt == $past(cnt) - 1'b1);

  // R5: the flag only rises from a tick taken at zero
  p_flag_on_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(tick) && $past(cnt) == '0));

  // R8: halt in immediate-stop mode freezes the counter
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(haltIn) && $past(emu) == 2'b00 && !$past(strb.reload) && !$past(strb.wrCntLo) && !$past(strb.wrCntHi))
    |-> $stable(cnt));
endmodule

bind tmr_top tmr_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .pscCnt(pscCnt),
  .period(period), .tick(tick), .flagQ(flagQ), .haltIn(haltIn), .emu(emuQ)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        haltIn = 1'b0;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_top u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
              .rdData(rdData), .haltIn(haltIn), .irq(irq));

  // {period, divide-down, expected clocks from start to irq}
  localparam logic [63:0] VEC [6] = '{
    {32'd3, 16'd1, 16'd8},
    {32'd0, 16'd0, 16'd1},
    {32'd5, 16'd0, 16'd6},
    {32'd2, 16'd3, 16'd12},
    {32'd0, 16'd4, 16'd5},
    {32'd7, 16'd2, 16'd24}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R11 reset values at the documented offsets
    rd(3'd0, v); chk("R1 cnt lo", v, 16'hFFFF);
    rd(3'd1, v); chk("R1 cnt hi", v, 16'hFFFF);
    rd(3'd2, v); chk("R1 prd lo", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 prd hi", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 ctrl", v, 16'h0010);
    rd(3'd6, v); chk("R1 psc lo", v, 16'h0000);
    rd(3'd7, v); chk("R1 psc hi", v, 16'h0000);
    rd(3'd5, v); chk("R11 offset5", v, 16'h0000);
    chk("R1 irq", irq, 1'b0);

    // R2 / R5 interrupt period table
    foreach (VEC[k]) begin
      wr(3'd2, VEC[k][47:32]);
      wr(3'd3, VEC[k][63:48]);
      wr(3'd6, {8'h00, VEC[k][23:16]});
      wr(3'd7, {8'h00, VEC[k][31:24]});
      wr(3'd4, 16'hC030);
      if (k == 0) begin
        rd(3'd4, v); chk("R3 reload reads 0", v, 16'h4010);
      end
      wr(3'd4, 16'h4000);
      n = 0;
      while (n < 200) begin
        @(negedge clk);
        n++;
        if (irq) break;
      end
      chk("R5 R2 clocks to irq", n, {16'h0, VEC[k][15:0]});
      rd(3'd0, v); chk("R5 reloaded lo", v, VEC[k][47:32]);
      wr(3'd4, 16'hC010);
    end

    // R4 stopped timer holds
    rd(3'd0, v);
    waitClk(5);
    begin
      logic [15:0] v2;
      rd(3'd0, v2); chk("R4 hold while stopped", v2, v);
    end

    // R6 / R7 flag and enable
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0000);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h8030);
    wr(3'd4, 16'h0000);
    waitClk(2);
    chk("R6 irq low without enable", irq, 1'b0);
    wr(3'd4, 16'h0010);
    rd(3'd4, v); chk("R5 flag set", v, 16'h8010);
    wr(3'd4, 16'h4010);
    chk("R6 irq with enable", irq, 1'b1);
    wr(3'd4, 16'h0010);
    chk("R6 irq after disable", irq, 1'b0);
    rd(3'd4, v); chk("R7 zero write keeps flag", v, 16'h8010);
    wr(3'd4, 16'h8010);
    rd(3'd4, v); chk("R7 w1c clears", v, 16'h0010);

    // R8 immediate halt
    wr(3'd2, 16'd5);
    wr(3'd4, 16'h0030);
    haltIn = 1'b1;
    wr(3'd4, 16'h0000);
    waitClk(5);
    rd(3'd0, v); chk("R8 frozen on halt", v, 16'd5);
    haltIn = 1'b0;
    waitClk(2);
    rd(3'd0, v); chk("R8 resumes", v, 16'd3);

    // R10 free run ignores halt
    wr(3'd4, 16'h0830);
    haltIn = 1'b1;
    wr(3'd4, 16'h0800);
    waitClk(3);
    rd(3'd0, v); chk("R10 free run", v, 16'd2);

    // R9 stop at zero
    wr(3'd4, 16'h0430);
    wr(3'd4, 16'h0400);
    waitClk(10);
    rd(3'd0, v); chk("R9 held at zero", v, 16'd0);
    rd(3'd4, v); chk("R9 no wrap flag", v, 16'h0400);
    haltIn = 1'b0;
    waitClk(1);
    rd(3'd0, v); chk("R9 wraps after release", v, 16'd5);
    rd(3'd4, v); chk("R9 flag after release", v, 16'h8400);

    // R11 counter writes, R3 prescaler reload
    wr(3'd4, 16'h8010);
    wr(3'd1, 16'h1234);
    wr(3'd0, 16'hABCD);
    rd(3'd0, v); chk("R11 cnt lo write", v, 16'hABCD);
    rd(3'd1, v); chk("R11 cnt hi write", v, 16'h1234);
    wr(3'd6, 16'h0003);
    wr(3'd4, 16'h0030);
    rd(3'd6, v); chk("R3 psc reload", v, 16'h0303);
    wr(3'd4, 16'h0000);
    waitClk(1);
    rd(3'd6, v); chk("R2 psc counts", v, 16'h0203);

    done = 1;
    finishRun();
  end
endmodule